// File: doc/BRIEF.md
# Coalescing Vector Gather Engine

This block gathers one 32-bit element per lane of a short SIMD register from memory. Each lane forms its effective byte address by adding its own index element to a shared scalar base. A per-lane pending mask records which lanes still need data. On each step the engine picks the lowest-numbered pending lane and requests the 64-byte line that holds that lane's address. When the line comes back, every pending lane whose address falls inside that line takes its word from it and drops its mask bit. Steps repeat until the mask is empty, so the number of memory accesses equals the number of distinct lines touched, not the number of lanes.

A command is started with a single-cycle `start` pulse that also captures the base, the index vector, the initial mask and the current destination contents. Lanes that are not selected by the initial mask keep their destination value. The memory side is a plain request/response port with at most one access in flight. A one-cycle `done` pulse marks completion. At that point the gathered vector and the final, empty mask are on the outputs.

Top module: `gather_coalesce`

## Requirements
- R1: A lane's effective address is `baseAddr` plus its index element, taken modulo 2^32. The request address `memAddr` is that address with its low 6 bits cleared.
- R2: Each request targets the line of the lowest-numbered lane whose mask bit is still set.
- R3: On a response, every pending lane whose address bits 31:6 equal the requested line loads the word selected by its address bits 5:2. Word w occupies `memRespData[32*w+31:32*w]`. The lane's mask bit then clears, and no other lane changes.
- R4: Steps repeat while any mask bit is set. The number of requests equals the number of distinct lines among the initially selected lanes. `done` is a one-cycle pulse and is raised only once the mask is empty.
- R5: With an all-zero initial mask, `done` is raised in the cycle after `start` is sampled, and no request is made.
- R6: Lanes whose initial mask bit is 0 keep the `destIn` value captured at start.
- R7: At most one request is outstanding. After `memReq` is raised, it stays low until the matching response has been accepted.
- R8: After reset, `memReq`, `done`, `maskOut` and `dataOut` are all zero.
- R9: A `start` pulse that arrives while a gather is in progress is ignored. It has no effect on the requests, the gathered data or the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a gather; inputs below are captured in the same cycle |
| baseAddr | input | 32 | Scalar base byte address |
| laneIdx | input | 256 | Per-lane byte index, lane l at bits 32*l+31:32*l |
| initMask | input | 8 | Lanes to fetch, bit l for lane l |
| destIn | input | 256 | Prior destination contents, same lane layout |
| memReq | output | 1 | One-cycle request strobe |
| memAddr | output | 32 | Line-aligned request address |
| memRespValid | input | 1 | Response strobe carrying one line |
| memRespData | input | 512 | Returned line, word w at bits 32*w+31:32*w |
| dataOut | output | 256 | Gathered vector |
| maskOut | output | 8 | Lanes still pending |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that memory returns exactly one `memRespValid` pulse per request and never responds while nothing is outstanding. They also assume that index values are word-aligned, so that bits 1:0 of every effective address are zero. The bench's memory responder keeps to both rules. It answers each observed request once, after a fixed latency, and every index it drives is a multiple of four. Late `start` pulses are the only deliberate out-of-protocol stimulus, and they are sent only to show that they are ignored.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef struct packed {
    logic load;    // capture command inputs
    logic issue;   // launch a line request
    logic retire;  // consume a returned line
  } gcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } gcState_t;
endpackage

// File: rtl/gc_pick_first.sv
module gc_pick_first #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gc_ctl.sv
module gc_ctl
  import gc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      maskZero,
  input  logic      memRespValid,
  output gcStrobe_t strobes,
  output logic      memReq,
  output logic      done
);
  gcState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    memReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (maskZero) begin
          done      = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          memReq        = 1'b1;
          strobes.issue = 1'b1;
          stateNext     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRespValid) begin
          strobes.retire = 1'b1;
          stateNext      = ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/gc_datapath.sv
module gc_datapath
  import gc_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFFS_W    = $clog2(LINE_BYTES),
  localparam int BYTE_OFF  = $clog2(WORD_W / 8),
  localparam int WSEL_W    = OFFS_W - BYTE_OFF,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int TAG_W     = ADDR_W - OFFS_W,
  localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  gcStrobe_t               strobes,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic [LANES*ADDR_W-1:0] laneIdx,
  input  logic [LANES-1:0]        initMask,
  input  logic [LANES*WORD_W-1:0] destIn,
  input  logic [LINE_W-1:0]       memRespData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    maskZero,
  output logic [LANES-1:0]        maskOut,
  output logic [LANES*WORD_W-1:0] dataOut
);
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [WORD_W-1:0] dataReg  [LANES];
  logic [LANES-1:0]  maskReg;
  logic [TAG_W-1:0]  accTag;
  logic [LANES-1:0]  hit;
  logic [WORD_W-1:0] respWord [LANES];
  logic [IDX_W-1:0]  firstIdx;
  logic              anyPending;
  logic [TAG_W-1:0]  firstTag;

  gc_pick_first #(.N(LANES)) uFirst (
    .req  (maskReg),
    .found(anyPending),
    .idx  (firstIdx)
  );

  assign firstTag = laneAddr[firstIdx][ADDR_W-1:OFFS_W];
  assign memAddr  = {firstTag, {OFFS_W{1'b0}}};
  assign maskZero = !anyPending;
  assign maskOut  = maskReg;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [WSEL_W-1:0] wordSel;
    assign wordSel     = laneAddr[l][OFFS_W-1:BYTE_OFF];
    assign hit[l]      = maskReg[l] && (laneAddr[l][ADDR_W-1:OFFS_W] == accTag);
    assign respWord[l] = memRespData[wordSel*WORD_W +: WORD_W];
    assign dataOut[l*WORD_W +: WORD_W] = dataReg[l];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      accTag  <= '0;
      for (int l = 0; l < LANES; l++) begin
        laneAddr[l] <= '0;
        dataReg[l]  <= '0;
      end
    end else begin
      if (strobes.issue) accTag <= firstTag;
      for (int l = 0; l < LANES; l++) begin
        if (strobes.load) begin
          laneAddr[l] <= baseAddr + laneIdx[l*ADDR_W +: ADDR_W];
          dataReg[l]  <= destIn[l*WORD_W +: WORD_W];
          maskReg[l]  <= initMask[l];
        end else if (strobes.retire && hit[l]) begin
          dataReg[l]  <= respWord[l];
          maskReg[l]  <= 1'b0;
        end
      end
    end
  end

  // R3: the lane that set the request address is always served by its response
  p_lowest_served_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retire |=> !maskReg[$past(firstIdx)]);

  // R3: every response shrinks the pending set
  p_retire_shrinks_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retire |=> ($countones(maskReg) < $countones($past(maskReg))));

  // R4: outside a load, pending bits can only clear
  p_mask_only_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ((maskReg & ~$past(maskReg)) == '0));
endmodule

// File: rtl/gather_coalesce.sv
module gather_coalesce
  import gc_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic [LANES*ADDR_W-1:0] laneIdx,
  input  logic [LANES-1:0]        initMask,
  input  logic [LANES*WORD_W-1:0] destIn,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memRespValid,
  input  logic [LINE_W-1:0]       memRespData,
  output logic [LANES*WORD_W-1:0] dataOut,
  output logic [LANES-1:0]        maskOut,
  output logic                    done
);
  gcStrobe_t strobes;
  logic      maskZero;

  gc_ctl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .maskZero    (maskZero),
    .memRespValid(memRespValid),
    .strobes     (strobes),
    .memReq      (memReq),
    .done        (done)
  );

  gc_datapath #(
    .LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baseAddr   (baseAddr),
    .laneIdx    (laneIdx),
    .initMask   (initMask),
    .destIn     (destIn),
    .memRespData(memRespData),
    .memAddr    (memAddr),
    .maskZero   (maskZero),
    .maskOut    (maskOut),
    .dataOut    (dataOut)
  );

  // R7: a request is never followed directly by another
  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R4: completion only with an empty mask
  p_done_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (maskOut == '0));

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: completion and a request never coincide
  p_done_no_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
endmodule

// File: tb/gather_coalesce_test.sv
module gather_coalesce_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int LAT   = 3;

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  maskAfter;
  } reqItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   baseAddr = '0;
  logic [255:0]  laneIdx = '0;
  logic [7:0]    initMask = '0;
  logic [255:0]  destIn = '0;
  logic          memReq;
  logic [31:0]   memAddr;
  logic          memRespValid = 1'b0;
  logic [511:0]  memRespData = '0;
  logic [255:0]  dataOut;
  logic [7:0]    maskOut;
  logic          done;

  int checks = 0;
  int errors = 0;
  int reqCount = 0;
  reqItem_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  gather_coalesce uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .laneIdx(laneIdx), .initMask(initMask), .destIn(destIn),
    .memReq(memReq), .memAddr(memAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .dataOut(dataOut), .maskOut(maskOut), .done(done)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor and memory responder: pops the scoreboard on every request
  initial begin
    @(negedge clk);
    forever begin
      if (memReq) begin
        reqItem_t it;
        reqCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected request", {32'h0, memAddr}, 64'h0);
          it.addr = memAddr;
          it.maskAfter = 8'h00;
        end else begin
          it = expQ.pop_front();
          check(memAddr == it.addr, "R2", "request line address",
                {32'h0, memAddr}, {32'h0, it.addr});
        end
        repeat (LAT - 1) begin
          @(negedge clk);
          check(!memReq, "R7", "second request while outstanding", {63'h0, memReq}, 64'h0);
        end
        for (int w = 0; w < 16; w++)
          memRespData[w*32 +: 32] = memWord(memAddr + 32'(w * 4));
        memRespValid = 1'b1;
        @(negedge clk);
        memRespValid = 1'b0;
        check(maskOut == it.maskAfter, "R3", "mask after response",
              {56'h0, maskOut}, {56'h0, it.maskAfter});
      end else begin
        @(negedge clk);
      end
    end
  end

  // Driver: builds the expected request sequence, runs the command, checks results
  task automatic runGather(input logic [31:0] base, input logic [31:0] idx[LANES],
                           input logic [7:0] mask, input logic [31:0] dst[LANES],
                           input bit poke, input string name);
    logic [31:0] addr[LANES];
    logic [31:0] expData[LANES];
    logic [7:0]  rem;
    int          nReq = 0;
    int          waitCnt = 0;
    for (int l = 0; l < LANES; l++) begin
      addr[l]    = base + idx[l];
      expData[l] = dst[l];
    end
    rem = mask;
    while (rem != 0) begin
      int f = 0;
      reqItem_t it;
      for (int l = LANES - 1; l >= 0; l--) if (rem[l]) f = l;
      for (int l = 0; l < LANES; l++) begin
        if (rem[l] && (addr[l][31:6] == addr[f][31:6])) begin
          expData[l] = memWord(addr[l]);
          rem[l] = 1'b0;
        end
      end
      it.addr = {addr[f][31:6], 6'h0};
      it.maskAfter = rem;
      expQ.push_back(it);
      nReq++;
    end
    reqCount = 0;
    @(negedge clk);
    baseAddr = base;
    initMask = mask;
    for (int l = 0; l < LANES; l++) begin
      laneIdx[l*32 +: 32] = idx[l];
      destIn[l*32 +: 32]  = dst[l];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mask == 8'h00) begin
      check(done == 1'b1, "R5", {name, " done right after start"}, {63'h0, done}, 64'h1);
      check(memReq == 1'b0, "R5", {name, " no request"}, {63'h0, memReq}, 64'h0);
    end
    if (poke) begin
      @(negedge clk);
      baseAddr = 32'hDEAD_0000;
      initMask = 8'h00;
      destIn   = {8{32'h1111_2222}};
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
    end
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, "R4", {name, " done seen"}, {63'h0, done}, 64'h1);
    check(maskOut == 8'h00, "R4", {name, " final mask empty"}, {56'h0, maskOut}, 64'h0);
    check(reqCount == nReq, "R4", {name, " request count"}, 64'(reqCount), 64'(nReq));
    check(expQ.size() == 0, "R4", {name, " all expected requests seen"}, 64'(expQ.size()), 64'h0);
    for (int l = 0; l < LANES; l++) begin
      check(dataOut[l*32 +: 32] == expData[l], mask[l] ? "R3" : "R6",
            $sformatf("%s lane %0d data", name, l),
            {32'h0, dataOut[l*32 +: 32]}, {32'h0, expData[l]});
    end
    expQ.delete();
    @(negedge clk);
    check(done == 1'b0, "R4", {name, " done is one cycle"}, {63'h0, done}, 64'h0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 64'h0, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] idx[LANES];
    logic [31:0] dst[LANES];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(memReq == 1'b0, "R8", "memReq after reset", {63'h0, memReq}, 64'h0);
    check(done == 1'b0, "R8", "done after reset", {63'h0, done}, 64'h0);
    check(maskOut == 8'h00, "R8", "mask after reset", {56'h0, maskOut}, 64'h0);
    check(dataOut == '0, "R8", "data after reset", dataOut[63:0], 64'h0);

    // R1 R3: all lanes in one line, shuffled word order
    for (int l = 0; l < LANES; l++) begin
      idx[l] = 32'(((l * 5) % 8) * 4 + 32);
      dst[l] = 32'hC0DE_0000 + 32'(l);
    end
    runGather(32'h0000_1000, idx, 8'hFF, dst, 1'b0, "oneLine");

    // R2 R4: every lane its own line, higher lanes at lower lines
    for (int l = 0; l < LANES; l++) idx[l] = 32'((7 - l) * 64 + l * 4);
    runGather(32'h0000_2000, idx, 8'hFF, dst, 1'b0, "eightLines");

    // R3 R6: partial mask, unaligned base, shared lines, skipped lanes
    idx[0] = 32'h208; idx[1] = 32'h208; idx[2] = 32'h30C; idx[3] = 32'h000;
    idx[4] = 32'h204; idx[5] = 32'h23C; idx[6] = 32'h310; idx[7] = 32'h310;
    runGather(32'h0000_4020, idx, 8'b1011_0110, dst, 1'b0, "partial");

    // R5: empty mask
    runGather(32'h0000_5000, idx, 8'h00, dst, 1'b0, "emptyMask");

    // R9: start pulse while busy is ignored
    for (int l = 0; l < LANES; l++) idx[l] = (l < 4) ? 32'(l * 4) : 32'(256 + l * 4);
    runGather(32'h0000_6000, idx, 8'hFF, dst, 1'b1, "R9 lateStart");

    // R1: address wraps past the top of the space
    for (int l = 0; l < LANES; l++) idx[l] = 32'(l * 16);
    runGather(32'hFFFF_FFC0, idx, 8'hFF, dst, 1'b0, "wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule